// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Row Counter

This block is the device-side control logic of a 256K x 16 DRAM whose pins are driven by asynchronous, active-low strobes: a row strobe, one column strobe per byte lane, a write enable and an output enable. A fast system clock oversamples every pin through a two-stage synchronizer. Edges are found on the synchronized copies, so every decision is made in one clock domain. From the order of those edges the decoder picks the cycle type: read, early write, read-write, row-strobe-only refresh, column-before-row refresh, or hidden refresh. It latches the row and the column from the shared 9-bit address bus and keeps a hidden 9-bit refresh row counter. For a small internal array it produces per-lane output enables and per-lane write strobes.

The data path has no valid/ready handshake, because the strobe protocol is its own flow control and the block never applies back-pressure. The host must hold each strobe level for at least `SYNC_STAGES + 1` clocks. Each row activation reports a one-clock refresh event, and each finished cycle reports a one-clock completion with its cycle kind. The array keeps only the low `ARR_ROW_BITS` of the row and the low `ARR_COL_BITS` of the column. Addresses that differ only in higher bits alias to the same word.

Top module: `dram_strobe_ctl`

## Requirements
- R1: After reset, `dq_oe` is 0, no `rfsh_stb`, `cyc_done` or `short_ras` pulse is given, and the refresh counter holds 0.
- R2: The internal column strobe becomes active when the first lane strobe (`cas_n[0]` for bits 7:0, `cas_n[1]` for bits 15:8) goes low, and the column is latched at that moment. A cycle whose row strobe has already risen completes only after the last lane strobe has returned high.
- R3: A cycle completes only once `ras_n` and every `cas_n` are high. Completion is one `cyc_done` pulse carrying `cyc_kind`: 1 read, 2 write, 3 read-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh. A completion pulse never coincides with a refresh pulse.
- R4: If any lane strobe is low when `ras_n` falls, the cycle is a counter refresh. It reports `rfsh_src`=1 with `rfsh_row` equal to the counter, ignores the address pins, writes nothing, keeps `dq_oe` at 0, and the counter then increments modulo 512.
- R5: If `ras_n` falls with all lane strobes high and no lane strobe follows, the cycle is a row-only refresh of the addressed row (`rfsh_src`=0, kind 4), and `dq_oe` stays 0.
- R6: A lane drives (`dq_oe` bit set, `dq_out` lane carrying the stored byte) only while its strobe is low, `we_n` is high, `oe_n` is low and a column has been latched. The other lane stays off.
- R7: A lane is written on the later of its strobe falling and `we_n` falling, and only lanes whose strobe is low are written. In an early write `dq_oe` stays 0.
- R8: A cycle that first drives read data and then writes under the same column strobe completes with kind 3.
- R9: If, after a read, the row strobe rises and falls again while a lane strobe stays low, that lane keeps driving the same data. The second fall is a counter refresh, and the cycle completes with kind 6.
- R10: Every read, write or row-only cycle gives one `rfsh_stb` at row activation with `rfsh_src`=0 and `rfsh_row` equal to the address pins.
- R11: `short_ras` pulses once when `ras_n` returns high after fewer than `MIN_RAS_CLKS` sampled low clocks, and never otherwise.
- R12: Within one row activation, each new fall of the internal column strobe latches a new column (page mode), for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, active low; bit 0 is the lower byte |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data; a lane that is not driven reads 0 |
| dq_oe | output | LANES | Per-lane drive enable |
| rfsh_stb | output | 1 | One-clock pulse when a row is refreshed |
| rfsh_row | output | ADDR_W | Row refreshed by the current pulse |
| rfsh_src | output | 1 | 1 if the row came from the internal counter |
| cyc_done | output | 1 | One-clock pulse at cycle completion |
| cyc_kind | output | 3 | Kind of the completed cycle, encoded as in R3 |
| short_ras | output | 1 | One-clock pulse on a too-short row strobe |

## Verification
Counter refresh and read-data drive can be active in the same clock. This happens in a hidden refresh, where the row strobe is cycled while a lane strobe is held low after a read. The bench provokes it by holding both lane strobes and the output enable low and then toggling only `ras_n`. It samples `dq_out` and `dq_oe` with the row strobe high and again with it low. Meanwhile a scoreboard expects a counter-sourced refresh event and a kind-6 completion, and must not see any completion before the last lane strobe is released.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_CBR,
    ST_HOLD
  } dec_state_t;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_READ   = 3'd1,
    KIND_WRITE  = 3'd2,
    KIND_RMW    = 3'd3,
    KIND_RONLY  = 3'd4,
    KIND_CBR    = 3'd5,
    KIND_HIDDEN = 3'd6
  } cyc_kind_t;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dsc_rfsh_ctr.sv
module dsc_rfsh_ctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end

  AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (row == $past(row) + 1'b1)); // R4
endmodule

// File: rtl/dsc_lane_array.sv
module dsc_lane_array #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/dsc_decoder.sv
module dsc_decoder
  import dsc_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int LANES        = 2,
  parameter int ROW_KEEP     = 3,
  parameter int COL_KEEP     = 3,
  parameter int MIN_RAS_CLKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ras,
  input  logic [LANES-1:0]             cas,
  input  logic                         we,
  input  logic                         oe,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [ADDR_W-1:0]            ctr_row,
  output logic [ROW_KEEP+COL_KEEP-1:0] arr_wr_addr,
  output logic [ROW_KEEP+COL_KEEP-1:0] arr_rd_addr,
  output logic [LANES-1:0]             lane_drive,
  output logic [LANES-1:0]             lane_wr,
  output logic                         ctr_step,
  output logic                         rfsh_stb,
  output logic [ADDR_W-1:0]            rfsh_row,
  output logic                         rfsh_src,
  output logic                         cyc_done,
  output cyc_kind_t                    cyc_kind,
  output logic                         short_ras
);
  localparam int CNT_W = $clog2(MIN_RAS_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RAS_CLKS);

  dec_state_t          state_q;
  logic                ras_q, we_q;
  logic [LANES-1:0]    cas_q;
  logic [ROW_KEEP-1:0] row_q;
  logic [COL_KEEP-1:0] col_q, col_eff;
  logic                had_cas_q, hidden_q, rd_seen_q, wr_seen_q;
  logic [CNT_W-1:0]    low_cnt_q;

  logic cas_any, cas_any_q, ras_on, ras_off, cas_on, we_on, col_valid, any_wr, any_drive;
  logic [LANES-1:0] lane_on;

  assign cas_any   = |cas;
  assign cas_any_q = |cas_q;
  assign ras_on    = ras & ~ras_q;
  assign ras_off   = ~ras & ras_q;
  assign cas_on    = cas_any & ~cas_any_q;
  assign we_on     = we & ~we_q;
  assign lane_on   = cas & ~cas_q;

  assign col_valid = had_cas_q & ((state_q == ST_OPEN) || (state_q == ST_HOLD) ||
                                  ((state_q == ST_CBR) && hidden_q));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_drive[g] = col_valid & cas[g] & ~we & oe;
    assign lane_wr[g]    = (state_q == ST_OPEN) & cas[g] & we & (lane_on[g] | we_on);
  end

  assign any_wr    = |lane_wr;
  assign any_drive = |lane_drive;
  assign col_eff   = cas_on ? addr[COL_KEEP-1:0] : col_q;
  assign arr_wr_addr = {row_q, col_eff};
  assign arr_rd_addr = {row_q, col_q};

  assign ctr_step = ras_on & cas_any & (state_q != ST_OPEN);

  function automatic cyc_kind_t classify(logic had, logic rd, logic wr);
    if (!had)          return KIND_RONLY;
    else if (rd && wr) return KIND_RMW;
    else if (wr)       return KIND_WRITE;
    else               return KIND_READ;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ras_q     <= 1'b0;
      cas_q     <= '0;
      we_q      <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      had_cas_q <= 1'b0;
      hidden_q  <= 1'b0;
      rd_seen_q <= 1'b0;
      wr_seen_q <= 1'b0;
      low_cnt_q <= '0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
      rfsh_src  <= 1'b0;
      cyc_done  <= 1'b0;
      cyc_kind  <= KIND_NONE;
      short_ras <= 1'b0;
    end else begin
      ras_q     <= ras;
      cas_q     <= cas;
      we_q      <= we;
      rfsh_stb  <= 1'b0;
      cyc_done  <= 1'b0;
      short_ras <= 1'b0;

      if (ras_on)                             low_cnt_q <= CNT_W'(1);
      else if (ras && low_cnt_q != CNT_MAX)   low_cnt_q <= low_cnt_q + 1'b1;
      if (ras_off && low_cnt_q < CNT_MAX)     short_ras <= 1'b1;

      if (any_drive) rd_seen_q <= 1'b1;
      if (any_wr)    wr_seen_q <= 1'b1;

      if (ctr_step) begin
        rfsh_stb <= 1'b1;
        rfsh_row <= ctr_row;
        rfsh_src <= 1'b1;
      end

      unique case (state_q)
        ST_IDLE: begin
          if (ras_on) begin
            had_cas_q <= 1'b0;
            rd_seen_q <= 1'b0;
            wr_seen_q <= 1'b0;
            hidden_q  <= 1'b0;
            if (cas_any) begin
              state_q <= ST_CBR;
            end else begin
              state_q  <= ST_OPEN;
              row_q    <= addr[ROW_KEEP-1:0];
              rfsh_stb <= 1'b1;
              rfsh_row <= addr;
              rfsh_src <= 1'b0;
            end
          end
        end
        ST_OPEN: begin
          if (cas_on) begin
            col_q     <= addr[COL_KEEP-1:0];
            had_cas_q <= 1'b1;
          end
          if (ras_off) begin
            if (cas_any) begin
              state_q <= ST_HOLD;
            end else begin
              state_q  <= ST_IDLE;
              cyc_done <= 1'b1;
              cyc_kind <= classify(had_cas_q | cas_on, rd_seen_q | any_drive,
                                   wr_seen_q | any_wr);
            end
          end
        end
        ST_HOLD: begin
          if (ras_on && cas_any) begin
            state_q  <= ST_CBR;
            hidden_q <= 1'b1;
          end else if (!cas_any && !ras) begin
            state_q  <= ST_IDLE;
            cyc_done <= 1'b1;
            cyc_kind <= classify(had_cas_q, rd_seen_q, wr_seen_q);
          end
        end
        ST_CBR: begin
          if (!ras && !cas_any) begin
            state_q  <= ST_IDLE;
            cyc_done <= 1'b1;
            cyc_kind <= hidden_q ? KIND_HIDDEN : KIND_CBR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> $past(!ras && !cas_any)); // R3
  AST_DONE_NOT_WITH_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_done && rfsh_stb)); // R3
  AST_REFRESH_AT_ACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |-> $past(ras_on)); // R10
  AST_SHORT_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    short_ras |-> $past(ras_off)); // R11
  AST_CBR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CBR && !hidden_q) |-> !any_drive); // R4
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl
  import dsc_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int LANES        = 2,
  parameter int LANE_W       = 8,
  parameter int ARR_ROW_BITS = 3,
  parameter int ARR_COL_BITS = 3,
  parameter int MIN_RAS_CLKS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ras_n,
  input  logic [LANES-1:0]        cas_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_oe,
  output logic                    rfsh_stb,
  output logic [ADDR_W-1:0]       rfsh_row,
  output logic                    rfsh_src,
  output logic                    cyc_done,
  output logic [2:0]              cyc_kind,
  output logic                    short_ras
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int ARR_AW = ARR_ROW_BITS + ARR_COL_BITS;
  localparam int STB_W  = LANES + 3;
  localparam int DAT_W  = ADDR_W + DATA_W;

  logic [STB_W-1:0]  stb_s;
  logic [DAT_W-1:0]  dat_s;
  logic              ras_s_n, we_s_n, oe_s_n;
  logic [LANES-1:0]  cas_s_n;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s, rd_word;
  logic [ADDR_W-1:0] ctr_row;
  logic              ctr_step;
  logic [ARR_AW-1:0] wr_addr, rd_addr;
  logic [LANES-1:0]  lane_drive, lane_wr;
  cyc_kind_t         kind;

  dsc_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, cas_n, ras_n}), .q(stb_s));

  dsc_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL({DAT_W{1'b0}})) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(dat_s));

  assign ras_s_n = stb_s[0];
  assign cas_s_n = stb_s[LANES:1];
  assign we_s_n  = stb_s[LANES+1];
  assign oe_s_n  = stb_s[LANES+2];
  assign addr_s  = dat_s[DAT_W-1:DATA_W];
  assign din_s   = dat_s[DATA_W-1:0];

  dsc_rfsh_ctr #(.ROW_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(ctr_step), .row(ctr_row));

  dsc_decoder #(
    .ADDR_W(ADDR_W), .LANES(LANES), .ROW_KEEP(ARR_ROW_BITS),
    .COL_KEEP(ARR_COL_BITS), .MIN_RAS_CLKS(MIN_RAS_CLKS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .ras(~ras_s_n), .cas(~cas_s_n), .we(~we_s_n), .oe(~oe_s_n),
    .addr(addr_s), .ctr_row(ctr_row),
    .arr_wr_addr(wr_addr), .arr_rd_addr(rd_addr),
    .lane_drive(lane_drive), .lane_wr(lane_wr), .ctr_step(ctr_step),
    .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .rfsh_src(rfsh_src),
    .cyc_done(cyc_done), .cyc_kind(kind), .short_ras(short_ras));

  dsc_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .AW(ARR_AW)) u_arr (
    .clk(clk), .wr_en(lane_wr), .wr_addr(wr_addr), .wr_data(din_s),
    .rd_addr(rd_addr), .rd_data(rd_word));

  assign cyc_kind = kind;
  assign dq_oe    = lane_drive;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_out[g*LANE_W +: LANE_W] = lane_drive[g] ? rd_word[g*LANE_W +: LANE_W] : '0;

    AST_DRIVE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[g] |-> (!cas_s_n[g] && we_s_n && !oe_s_n)); // R6
    AST_WRITE_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      lane_wr[g] |-> (!cas_s_n[g] && !we_s_n)); // R7
  end
endmodule

// File: tb/tb_dram_strobe_ctl.sv
module tb_dram_strobe_ctl;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, we_n, oe_n;
  logic [1:0]  cas_n;
  logic [8:0]  addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;
  logic        rfsh_stb, rfsh_src, cyc_done, short_ras;
  logic [8:0]  rfsh_row;
  logic [2:0]  cyc_kind;

  always #5 clk = ~clk;

  dram_strobe_ctl dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row), .rfsh_src(rfsh_src),
    .cyc_done(cyc_done), .cyc_kind(cyc_kind), .short_ras(short_ras));

  int vectors = 0;
  int miscompares = 0;
  int shorts_seen = 0;
  int shorts_exp = 0;
  logic [8:0] ctr_m = '0;
  logic [15:0] model [int];

  logic [9:0] rf_q[$];
  string      rf_tag[$];
  logic [2:0] kd_q[$];
  string      kd_tag[$];

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_rf(logic [8:0] row, logic src, string tag);
    rf_q.push_back({row, src});
    rf_tag.push_back(tag);
  endtask

  task automatic push_kd(logic [2:0] k, string tag);
    kd_q.push_back(k);
    kd_tag.push_back(tag);
  endtask

  function automatic int key(logic [8:0] row, logic [8:0] col);
    return int'(row) * 512 + int'(col);
  endfunction

  function automatic logic [15:0] lmask(logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Monitor: pops the scoreboard on each event pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (rfsh_stb) begin
        if (rf_q.size() == 0) check("R10 unexpected refresh event", {rfsh_row, rfsh_src}, 0);
        else begin
          logic [9:0] e;
          string t;
          e = rf_q.pop_front();
          t = rf_tag.pop_front();
          check(t, {22'd0, rfsh_row, rfsh_src}, {22'd0, e});
        end
      end
      if (cyc_done) begin
        if (kd_q.size() == 0) check("R3 unexpected completion", cyc_kind, 7);
        else begin
          logic [2:0] k;
          string t;
          k = kd_q.pop_front();
          t = kd_tag.pop_front();
          check(t, cyc_kind, k);
        end
      end
      if (short_ras) shorts_seen++;
    end
  end

  task automatic wr_cyc(logic [8:0] row, logic [8:0] col, logic [15:0] d, logic [1:0] m);
    push_rf(row, 1'b0, "R10 write refreshes addressed row");
    addr = row; ras_n = 0; step(S);
    addr = col; dq_in = d; we_n = 0; cas_n = ~m; step(S);
    check("R7 early write keeps lanes off", dq_oe, 0);
    cas_n = '1; we_n = 1; step(S);
    push_kd(3'd2, "R7 write kind");
    ras_n = 1; step(S);
    if (!model.exists(key(row, col))) model[key(row, col)] = '0;
    model[key(row, col)] = (model[key(row, col)] & ~lmask(m)) | (d & lmask(m));
  endtask

  task automatic rd_cyc(logic [8:0] row, logic [8:0] col, logic [1:0] m, string tag);
    push_rf(row, 1'b0, "R10 read refreshes addressed row");
    addr = row; ras_n = 0; step(S);
    addr = col; oe_n = 0; cas_n = ~m; step(S);
    check({tag, " lane enables"}, dq_oe, m);
    check({tag, " read data"}, dq_out & lmask(m), model[key(row, col)] & lmask(m));
    cas_n = '1; oe_n = 1; step(S);
    push_kd(3'd1, "R3 read kind");
    ras_n = 1; step(S);
  endtask

  task automatic cbr_cyc();
    push_rf(ctr_m, 1'b1, "R4 counter row");
    addr = 9'h155; cas_n = 2'b00; step(S);
    ras_n = 0; step(S);
    check("R4 counter refresh keeps lanes off", dq_oe, 0);
    ras_n = 1; step(S);
    push_kd(3'd5, "R4 counter refresh kind");
    cas_n = '1; step(S);
    ctr_m = ctr_m + 1'b1;
  endtask

  initial begin
    rst_n = 0; ras_n = 1; cas_n = '1; we_n = 1; oe_n = 1; addr = '0; dq_in = '0;
    step(5);
    rst_n = 1;
    step(3);
    check("R1 reset lanes off", dq_oe, 0);
    check("R1 reset pulses idle", {rfsh_stb, cyc_done, short_ras}, 0);

    wr_cyc(9'd1, 9'd2, 16'h1234, 2'b11);
    rd_cyc(9'd1, 9'd2, 2'b11, "R6 word read");
    rd_cyc(9'd1, 9'd2, 2'b01, "R6 lower lane only");
    wr_cyc(9'd1, 9'd2, 16'hAAAA, 2'b10);
    rd_cyc(9'd1, 9'd2, 2'b11, "R7 upper lane only written");

    // output enable held high: no drive
    push_rf(9'd1, 1'b0, "R10 read refreshes addressed row");
    addr = 9'd1; ras_n = 0; step(S);
    addr = 9'd2; cas_n = 2'b00; step(S);
    check("R6 no drive with output enable high", dq_oe, 0);
    cas_n = '1; step(S);
    push_kd(3'd1, "R3 read kind");
    ras_n = 1; step(S);

    // read-write
    wr_cyc(9'd2, 9'd5, 16'h5678, 2'b11);
    push_rf(9'd2, 1'b0, "R10 read-write row");
    addr = 9'd2; ras_n = 0; step(S);
    addr = 9'd5; oe_n = 0; cas_n = 2'b00; step(S);
    check("R8 read phase data", dq_out, 16'h5678);
    oe_n = 1; we_n = 0; dq_in = 16'h9ABC; step(S);
    check("R8 write phase lanes off", dq_oe, 0);
    cas_n = '1; we_n = 1; step(S);
    push_kd(3'd3, "R8 read-write kind");
    ras_n = 1; step(S);
    model[key(2, 5)] = 16'h9ABC;
    rd_cyc(9'd2, 9'd5, 2'b11, "R8 read back");

    // page mode writes and reads
    push_rf(9'd3, 1'b0, "R12 page write row");
    addr = 9'd3; ras_n = 0; step(S);
    we_n = 0;
    addr = 9'd0; dq_in = 16'h0F0F; cas_n = 2'b00; step(S);
    cas_n = '1; step(S);
    addr = 9'd1; dq_in = 16'hF0F0; cas_n = 2'b00; step(S);
    cas_n = '1; we_n = 1; step(S);
    push_kd(3'd2, "R12 page write kind");
    ras_n = 1; step(S);
    push_rf(9'd3, 1'b0, "R12 page read row");
    addr = 9'd3; ras_n = 0; step(S);
    oe_n = 0;
    addr = 9'd0; cas_n = 2'b00; step(S);
    check("R12 first column", dq_out, 16'h0F0F);
    cas_n = '1; step(S);
    addr = 9'd1; cas_n = 2'b00; step(S);
    check("R12 second column", dq_out, 16'hF0F0);
    cas_n = '1; oe_n = 1; step(S);
    push_kd(3'd1, "R12 page read kind");
    ras_n = 1; step(S);
    model[key(3, 0)] = 16'h0F0F;
    model[key(3, 1)] = 16'hF0F0;

    // row-only refresh
    push_rf(9'd7, 1'b0, "R5 row-only row");
    addr = 9'd7; ras_n = 0; step(S);
    check("R5 row-only lanes off", dq_oe, 0);
    push_kd(3'd4, "R5 row-only kind");
    ras_n = 1; step(S);

    // counter refresh, address ignored, no data disturbed
    cbr_cyc();
    rd_cyc(9'd1, 9'd2, 2'b11, "R4 data intact after counter refresh");

    // internal strobe: first fall latches column, last rise ends cycle
    push_rf(9'd1, 1'b0, "R2 row");
    addr = 9'd1; ras_n = 0; step(S);
    oe_n = 0; addr = 9'd2; cas_n = 2'b10; step(S);
    addr = 9'd7; cas_n = 2'b00; step(S);
    check("R2 column from first lane fall", dq_out, model[key(1, 2)]);
    check("R2 both lanes drive", dq_oe, 2'b11);
    cas_n = 2'b01; step(S);
    check("R2 lower lane released", dq_oe, 2'b10);
    ras_n = 1; step(S);
    check("R2 upper lane held past row release", dq_oe, 2'b10);
    push_kd(3'd1, "R2 completes after last lane rise");
    cas_n = '1; oe_n = 1; step(S);

    // hidden refresh
    push_rf(9'd3, 1'b0, "R9 read row");
    addr = 9'd3; ras_n = 0; step(S);
    oe_n = 0; addr = 9'd1; cas_n = 2'b00; step(S);
    check("R9 read before hidden refresh", dq_out, 16'hF0F0);
    ras_n = 1; step(S);
    check("R9 data held with row high", dq_out, 16'hF0F0);
    push_rf(ctr_m, 1'b1, "R9 hidden refresh uses counter");
    addr = 9'd0; ras_n = 0; step(S);
    check("R9 data held during hidden refresh", dq_out, 16'hF0F0);
    check("R9 lanes held during hidden refresh", dq_oe, 2'b11);
    ras_n = 1; step(S);
    push_kd(3'd6, "R9 hidden kind");
    cas_n = '1; oe_n = 1; step(S);
    ctr_m = ctr_m + 1'b1;

    // short row strobe
    push_rf(9'd5, 1'b0, "R11 short cycle row");
    addr = 9'd5; ras_n = 0; step(2);
    push_kd(3'd4, "R11 short cycle kind");
    ras_n = 1; step(S);
    shorts_exp = 1;

    // counter wrap
    for (int i = 0; i < 512; i++) cbr_cyc();

    step(8);
    check("R11 short pulses", shorts_seen, shorts_exp);
    check("R10 refresh events all seen", rf_q.size(), 0);
    check("R3 completions all seen", kd_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule